// File: doc/BRIEF.md
# Receive FIFO Burst Writer

This block moves read data out of a local staging buffer and into a receive FIFO owned by the user. The data always travels in bursts of 512 bytes. The buffer word is 256 bits wide, so each burst is sixteen words. A command gives a total length counted in 512-byte units. The block then does two jobs at once:

- It asks an upstream storage engine for read chunks. A full chunk is 128 KB. The final chunk carries whatever length remains.
- It drains whatever the engine has written into the buffer out to the user FIFO.

A chunk is requested only when the buffer has free room for the whole chunk. Free room means the buffer size minus the bursts already requested and not yet handed to the user. A burst starts only if both of these hold:

- The user FIFO shows room. The block reads only bits [15:5] of the FIFO's 16-bit write count, and those bits must not all be ones.
- The buffer holds at least one burst of data.

The command completes only after every requested word has reached the user, so the buffer is empty again at that point.

The buffer size is chosen by a parameter: a high-speed size of 1 MB or a small size of 256 KB. A second parameter divides the buffer size and the chunk size by a power of two. This allows the block to be elaborated small; the default divides by 16. The storage engine is outside the block. It writes words into the buffer through a simple fill port, in the order it receives them.

Top module: `rdb_rx_drain`

## Requirements
- R1: While `busy` is low, a `start` pulse latches `total_len` and `busy` is high from the next cycle. A `start` pulse while `busy` is high has no effect on the command in progress.
- R2: A burst begins only if `fifo_wr_cnt` was below 16'hFFE0 (bits [15:5] not all ones) two cycles before its first `fifo_wr_en` beat. A FIFO whose count is narrower than 16 bits must have its unused upper bits tied to 1.
- R3: Every burst drives `fifo_wr_en` high for exactly 16 consecutive cycles. FIFO room is checked only between bursts, so a full indication that arrives mid-burst does not cut the burst short.
- R4: A burst begins only when the buffer holds at least 16 words. Words reach `fifo_wr_data` in the order they were written through the fill port.
- R5: Each `chunk_req` pulse carries a `chunk_len`, in 512-byte units, equal to the smaller of the full chunk (128 KB scaled) and the length not yet requested. The sum of all chunk lengths equals `total_len`.
- R6: A chunk is issued only when the buffer size in bursts, minus the outstanding bursts, is at least `chunk_len`. Outstanding bursts are those requested but not yet written to the FIFO.
- R7: No `chunk_req` is issued once the length still to be requested reaches zero, and none is issued while `busy` is low.
- R8: `busy` falls in the cycle right after the final `fifo_wr_en` beat. By then exactly 16 x `total_len` beats have been written and the buffer is empty.
- R9: The buffer holds 2048 bursts (1 MB) when `HIGH_SPEED`=1 and 512 bursts (256 KB) otherwise, both shifted right by `SCALE_SHIFT`. With the defaults this is 32 bursts, and a full chunk is 16 bursts.
- R10: After reset, `busy`, `chunk_req` and `fifo_wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle command request, accepted only while idle |
| total_len | input | LEN_W | Command length in 512-byte units (at least 1) |
| fifo_wr_cnt | input | 16 | Write-side fill count of the user receive FIFO |
| fill_en | input | 1 | Storage engine writes one word into the buffer |
| fill_data | input | DATA_W | Word written by the storage engine |
| busy | output | 1 | High while a command is active |
| chunk_req | output | 1 | One-cycle request for the next read chunk |
| chunk_len | output | LEN_W | Size of the requested chunk in 512-byte units |
| fifo_wr_en | output | 1 | Write strobe into the user receive FIFO |
| fifo_wr_data | output | DATA_W | Data word for the user receive FIFO |

## Verification
The assertions assume that the storage engine writes only what has been requested, so the fill port can never overrun the buffer. They also assume that `total_len` is non-zero and that the FIFO count is padded with ones when the FIFO is narrower than 16 bits.

The bench's fill stub follows these rules. It adds exactly `chunk_len` x 16 words to its pending amount for each request and writes them at a chosen pace. Every command length used is between 1 and 40.

The FIFO count is driven in three ways: held open, held at all ones, or switched every cycle between values just below and at the threshold. This keeps stalls in range while also landing full indications inside bursts.

// File: rtl/rdb_pkg.sv
package rdb_pkg;
  // One transfer unit of 512 bytes is sixteen 256-bit words.
  localparam int unsigned BEATS_PER_BURST   = 16;
  // A 128 KB chunk expressed in 512-byte units.
  localparam int unsigned FULL_CHUNK_BURSTS = 256;
  // Buffer capacities in 512-byte units: 1 MB and 256 KB.
  localparam int unsigned HS_BUF_BURSTS     = 2048;
  localparam int unsigned SM_BUF_BURSTS     = 512;

  typedef enum logic [0:0] {
    BW_IDLE = 1'b0,
    BW_RUN  = 1'b1
  } bw_state_e;
endpackage

// File: rtl/rdb_buffer.sv
module rdb_buffer #(
  parameter int DATA_W = 256,
  parameter int DEPTH  = 512,
  parameter int OCC_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [OCC_W-1:0]  occ
);
  localparam int AW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp_q;
  logic [AW-1:0]     rp_q;

  // Simple dual-port array with registered read, suitable for block RAM.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wp_q] <= wr_data;
    if (rd_en) rd_data <= mem[rp_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q <= '0;
      rp_q <= '0;
      occ  <= '0;
    end else begin
      if (wr_en) wp_q <= wp_q + 1'b1;
      if (rd_en) rp_q <= rp_q + 1'b1;
      unique case ({wr_en, rd_en})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end
endmodule

// File: rtl/rdb_chunk_issuer.sv
module rdb_chunk_issuer #(
  parameter int LEN_W        = 32,
  parameter int CHUNK_BURSTS = 16,
  parameter int BUF_BURSTS   = 32,
  parameter int OUT_W        = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] total_len,
  input  logic             en,
  input  logic             burst_done,
  output logic             chunk_req,
  output logic [LEN_W-1:0] chunk_len,
  output logic [OUT_W-1:0] outstanding
);
  localparam logic [LEN_W-1:0] CHUNK_L = LEN_W'(CHUNK_BURSTS);
  localparam logic [LEN_W-1:0] BUF_L   = LEN_W'(BUF_BURSTS);

  logic [LEN_W-1:0] remain_q;
  logic [LEN_W-1:0] next_len;
  logic [LEN_W-1:0] free_l;
  logic             fire;

  always_comb begin
    next_len = (remain_q > CHUNK_L) ? CHUNK_L : remain_q;
    free_l   = BUF_L - LEN_W'(outstanding);
    fire     = en && (remain_q != '0) && (free_l >= next_len);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q    <= '0;
      chunk_req   <= 1'b0;
      chunk_len   <= '0;
      outstanding <= '0;
    end else begin
      chunk_req <= fire;
      if (fire) chunk_len <= next_len;
      if (load)      remain_q <= total_len;
      else if (fire) remain_q <= remain_q - next_len;
      outstanding <= outstanding
                   + (fire ? OUT_W'(next_len) : OUT_W'(0))
                   - (burst_done ? OUT_W'(1) : OUT_W'(0));
    end
  end
endmodule

// File: rtl/rdb_burst_ctrl.sv
module rdb_burst_ctrl
  import rdb_pkg::*;
#(
  parameter int LEN_W = 32,
  parameter int OCC_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             en,
  input  logic [LEN_W-1:0] total_len,
  input  logic [15:0]      fifo_wr_cnt,
  input  logic [OCC_W-1:0] buf_occ,
  output logic             rd_en,
  output logic             wr_en,
  output logic             wr_last
);
  localparam int BW = $clog2(BEATS_PER_BURST);

  bw_state_e        state_q;
  logic [BW-1:0]    beat_q;
  logic [LEN_W-1:0] bursts_q;
  logic             space_ok;
  logic             data_ok;
  logic             more;
  logic             go;
  logic             last_beat;

  always_comb begin
    // Bits [15:5] all ones is exactly count >= 16'hFFE0.
    space_ok  = fifo_wr_cnt < 16'hFFE0;
    data_ok   = buf_occ >= OCC_W'(BEATS_PER_BURST);
    more      = bursts_q != total_len;
    go        = (state_q == BW_IDLE) && en && space_ok && data_ok && more;
    rd_en     = (state_q == BW_RUN);
    last_beat = rd_en && (beat_q == BW'(BEATS_PER_BURST - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= BW_IDLE;
      beat_q   <= '0;
      bursts_q <= '0;
      wr_en    <= 1'b0;
      wr_last  <= 1'b0;
    end else begin
      wr_en   <= rd_en;
      wr_last <= last_beat;
      if (load) bursts_q <= '0;
      unique case (state_q)
        BW_IDLE: if (go) begin
          state_q <= BW_RUN;
          beat_q  <= '0;
        end
        BW_RUN: begin
          beat_q <= beat_q + 1'b1;
          if (last_beat) begin
            state_q  <= BW_IDLE;
            bursts_q <= bursts_q + 1'b1;
          end
        end
        default: state_q <= BW_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rdb_rx_drain.sv
module rdb_rx_drain
  import rdb_pkg::*;
#(
  parameter int DATA_W      = 256,
  parameter int LEN_W       = 32,
  parameter int HIGH_SPEED  = 0,
  parameter int SCALE_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LEN_W-1:0]  total_len,
  input  logic [15:0]       fifo_wr_cnt,
  input  logic              fill_en,
  input  logic [DATA_W-1:0] fill_data,
  output logic              busy,
  output logic              chunk_req,
  output logic [LEN_W-1:0]  chunk_len,
  output logic              fifo_wr_en,
  output logic [DATA_W-1:0] fifo_wr_data
);
  localparam int CHUNK_BURSTS = int'(FULL_CHUNK_BURSTS) >> SCALE_SHIFT;
  localparam int BUF_BURSTS   = (HIGH_SPEED != 0 ? int'(HS_BUF_BURSTS)
                                                 : int'(SM_BUF_BURSTS)) >> SCALE_SHIFT;
  localparam int BUF_WORDS    = BUF_BURSTS * int'(BEATS_PER_BURST);
  localparam int OCC_W        = $clog2(BUF_WORDS + 1);
  localparam int OUT_W        = $clog2(BUF_BURSTS + 1);

  logic             busy_q;
  logic [LEN_W-1:0] total_q;
  logic [LEN_W-1:0] done_q;
  logic             load;
  logic             finish;
  logic             rd_en;
  logic             wr_last;
  logic [OCC_W-1:0] buf_occ;
  logic [OUT_W-1:0] outstanding;

  assign busy   = busy_q;
  assign load   = start && !busy_q;
  assign finish = busy_q && wr_last && ((done_q + LEN_W'(1)) == total_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      total_q <= '0;
      done_q  <= '0;
    end else if (load) begin
      busy_q  <= 1'b1;
      total_q <= total_len;
      done_q  <= '0;
    end else begin
      if (wr_last) done_q <= done_q + LEN_W'(1);
      if (finish)  busy_q <= 1'b0;
    end
  end

  rdb_buffer #(
    .DATA_W (DATA_W),
    .DEPTH  (BUF_WORDS),
    .OCC_W  (OCC_W)
  ) u_buf (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (fill_en),
    .wr_data (fill_data),
    .rd_en   (rd_en),
    .rd_data (fifo_wr_data),
    .occ     (buf_occ)
  );

  rdb_chunk_issuer #(
    .LEN_W        (LEN_W),
    .CHUNK_BURSTS (CHUNK_BURSTS),
    .BUF_BURSTS   (BUF_BURSTS),
    .OUT_W        (OUT_W)
  ) u_issue (
    .clk         (clk),
    .rst         (rst),
    .load        (load),
    .total_len   (total_len),
    .en          (busy_q),
    .burst_done  (wr_last),
    .chunk_req   (chunk_req),
    .chunk_len   (chunk_len),
    .outstanding (outstanding)
  );

  rdb_burst_ctrl #(
    .LEN_W (LEN_W),
    .OCC_W (OCC_W)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .load        (load),
    .en          (busy_q),
    .total_len   (total_q),
    .fifo_wr_cnt (fifo_wr_cnt),
    .buf_occ     (buf_occ),
    .rd_en       (rd_en),
    .wr_en       (fifo_wr_en),
    .wr_last     (wr_last)
  );
endmodule

// File: rtl/rdb_rx_drain_chk.sv
module rdb_rx_drain_chk #(
  parameter int OCC_W      = 10,
  parameter int OUT_W      = 6,
  parameter int BUF_WORDS  = 512,
  parameter int BUF_BURSTS = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             chunk_req,
  input logic             fifo_wr_en,
  input logic             rd_en,
  input logic [15:0]      fifo_wr_cnt,
  input logic [OCC_W-1:0] buf_occ,
  input logic [OUT_W-1:0] outstanding
);
  logic [4:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)             run_q <= '0;
    else if (fifo_wr_en) run_q <= run_q + 1'b1;
    else                 run_q <= '0;
  end

  p_run_max_r3: assert property (@(posedge clk) disable iff (rst)
    fifo_wr_en |-> run_q < 5'd16);

  p_run_full_r3: assert property (@(posedge clk) disable iff (rst)
    (!fifo_wr_en && run_q != 5'd0) |-> run_q == 5'd16);

  p_space_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_en) |-> $past(fifo_wr_cnt) < 16'hFFE0);

  p_data_ready_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_en) |-> $past(buf_occ) >= OCC_W'(16));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    buf_occ <= OCC_W'(BUF_WORDS));

  p_credit_r6: assert property (@(posedge clk) disable iff (rst)
    outstanding <= OUT_W'(BUF_BURSTS));

  p_done_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (buf_occ == '0) && $past(fifo_wr_en));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !chunk_req);
endmodule

bind rdb_rx_drain rdb_rx_drain_chk #(
  .OCC_W      (OCC_W),
  .OUT_W      (OUT_W),
  .BUF_WORDS  (BUF_WORDS),
  .BUF_BURSTS (BUF_BURSTS)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .busy        (busy),
  .chunk_req   (chunk_req),
  .fifo_wr_en  (fifo_wr_en),
  .rd_en       (rd_en),
  .fifo_wr_cnt (fifo_wr_cnt),
  .buf_occ     (buf_occ),
  .outstanding (outstanding)
);

// File: tb/tb_rdb_rx_drain.sv
module tb_rdb_rx_drain;
  localparam int DATA_W = 256;
  localparam int LEN_W  = 32;
  localparam int CH     = 256 >> 4;   // R9: full chunk, scaled
  localparam int BUFB   = 512 >> 4;   // R9: small buffer, scaled

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [LEN_W-1:0]  total_len = '0;
  logic [15:0]       fifo_wr_cnt = '0;
  logic              fill_en = 1'b0;
  logic [DATA_W-1:0] fill_data = '0;
  logic              busy, chunk_req, fifo_wr_en;
  logic [LEN_W-1:0]  chunk_len;
  logic [DATA_W-1:0] fifo_wr_data;

  always #2 clk = ~clk;

  rdb_rx_drain dut (
    .clk(clk), .rst(rst), .start(start), .total_len(total_len),
    .fifo_wr_cnt(fifo_wr_cnt), .fill_en(fill_en), .fill_data(fill_data),
    .busy(busy), .chunk_req(chunk_req), .chunk_len(chunk_len),
    .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  int unsigned fill_idx = 0, out_idx = 0, pending = 0;
  int          fill_gap = 1, tick = 0, cnt_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  int          b_rem = 0, b_out = 0, exp_len = 0, beats_cmd = 0, run_len = 0;
  logic [15:0] cnt_h1 = '0, cnt_h2 = '0;
  logic        prev_wr = 1'b0, prev_busy = 1'b0;

  function automatic logic [DATA_W-1:0] pat(input int unsigned k);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < 8; i++)
      r[i*32 +: 32] = (k * 32'h9E3779B1) ^ (32'(i) * 32'h01000193) ^ 32'h5A5A0000;
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Storage stub and FIFO-count driver, away from the clock edge.
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (cnt_mode)
      0:       fifo_wr_cnt = 16'h0000;
      1:       fifo_wr_cnt = lfsr[1:0] == 2'd0 ? 16'hFFDF :
                             lfsr[1:0] == 2'd1 ? 16'hFFE0 :
                             lfsr[1:0] == 2'd2 ? 16'hFFFF : 16'h0010;
      default: fifo_wr_cnt = 16'hFFFF;
    endcase
    if (rst) begin
      fill_en = 1'b0;
      pending = 0;
    end else begin
      if (chunk_req) pending += 32'(chunk_len) * 16;
      tick++;
      fill_en = 1'b0;
      if (pending > 0 && (tick % fill_gap) == 0) begin
        fill_en   = 1'b1;
        fill_data = pat(fill_idx);
        fill_idx++;
        pending--;
      end
    end
  end

  // Output monitor, sampled at the falling edge.
  always @(negedge clk) begin
    if (!rst) begin
      if (chunk_req) begin
        int e;
        e = (b_rem > CH) ? CH : b_rem;
        chk(b_rem != 0, "R7 chunk issued with nothing left", chunk_len, 0);
        chk(int'(chunk_len) == e, "R5 chunk length", chunk_len, e);
        chk(b_out + int'(chunk_len) <= BUFB, "R6 chunk exceeds free space",
            b_out + int'(chunk_len), BUFB);
        b_rem -= int'(chunk_len);
        b_out += int'(chunk_len);
      end
      if (fifo_wr_en) begin
        if (!prev_wr) chk(cnt_h2 < 16'hFFE0, "R2 burst began with FIFO full", cnt_h2, 16'hFFDF);
        chk(fifo_wr_data == pat(out_idx), "R4 data order", fifo_wr_data, pat(out_idx));
        out_idx++;
        run_len++;
        beats_cmd++;
        if (run_len == 16) b_out--;
      end else if (prev_wr) begin
        chk(run_len == 16, "R3 burst length", run_len, 16);
        run_len = 0;
      end
      if (prev_busy && !busy) begin
        chk(prev_wr && !fifo_wr_en, "R8 busy falls after last beat", {prev_wr, fifo_wr_en}, 2'b10);
        chk(beats_cmd == 16 * exp_len, "R8 total beats", beats_cmd, 16 * exp_len);
        chk(b_rem == 0 && b_out == 0, "R8 all requested data delivered", b_rem + b_out, 0);
      end
      cnt_h2    = cnt_h1;
      cnt_h1    = fifo_wr_cnt;
      prev_wr   = fifo_wr_en;
      prev_busy = busy;
    end
  end

  task automatic kick(input int len);
    @(posedge clk); #1;
    exp_len   = len;
    beats_cmd = 0;
    b_rem     = len;
    total_len = LEN_W'(len);
    start     = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk);
    chk(busy == 1'b1, "R1 busy after start", busy, 1);
  endtask

  task automatic wait_done();
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog: run hung");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R10
    chk(busy == 1'b0, "R10 busy after reset", busy, 0);
    chk(fifo_wr_en == 1'b0, "R10 write enable after reset", fifo_wr_en, 0);
    chk(chunk_req == 1'b0, "R10 chunk request after reset", chunk_req, 0);

    // Open FIFO, every length 1..40, varying fill pace (R3 R4 R5 R6 R8).
    for (int len = 1; len <= 40; len++) begin
      fill_gap = 1 + (len % 3);
      kick(len);
      wait_done();
    end

    // FIFO count hovering at the threshold (R2, R3 mid-burst full).
    cnt_mode = 1;
    for (int len = 1; len <= 24; len++) begin
      fill_gap = 1 + (len % 2);
      kick(len);
      wait_done();
    end
    cnt_mode = 0;

    // FIFO full: buffer fills to its size, then nothing drains (R2, R6, R9).
    begin
      int unsigned seen;
      fill_gap = 1;
      cnt_mode = 2;
      seen = out_idx;
      kick(40);
      repeat (300) @(negedge clk);
      chk(b_out == BUFB, "R9 buffer filled to its size", b_out, BUFB);
      chk(out_idx == seen, "R2 no write while FIFO full", out_idx, seen);
      cnt_mode = 0;
      wait_done();
    end

    // Start while busy is ignored (R1).
    fill_gap = 2;
    kick(20);
    repeat (30) @(posedge clk);
    #1;
    total_len = LEN_W'(7);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    wait_done();
    chk(beats_cmd == 16 * 20, "R1 second start ignored", beats_cmd, 16 * 20);
    chk(busy == 1'b0, "R1 idle after command", busy, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule